// File: doc/BRIEF.md
# Serial Lane Loopback and Polarity Steering

This block sits between two retimed serial lanes of a transceiver and two output lanes. One input is the stream recovered from the line (optical) side, the other is the stream arriving from the host-side electrical interface. Both are presented as parallel words in a single core clock domain. The block decides which input drives each output: normal pass-through, a system loopback that returns host data to the host, or a line-side loopback that returns line data to the line. Polarity inversion and squelch are then applied to each output on its own.

Control comes from a plain write port with an enable, an address and a data byte. A sticky flag reports an illegal attempt to enable both loopbacks at once. A software-reset command returns all control settings to normal pass-through.

Top module: `lane_loop_steer`

## Requirements
- R1: With both loopback bits clear, the receive output carries the line input and the transmit output carries the host input.
- R2: Control register address 0 bit 0 enables system loopback. The receive output then carries the host input, and the transmit output is forced to an all-zeros word.
- R3: Control register address 0 bit 1 enables line-side loopback. The transmit output then carries the line input, and the receive output is forced to an all-zeros word.
- R4: If address 0 bits 0 and 1 are both set, system loopback wins. The `cfgError` output goes high one cycle after the write and stays high until reset or software reset.
- R5: Address 0 bit 2 inverts every bit of the receive output, and bit 4 inverts every bit of the transmit output. Inversion is applied after the source is chosen.
- R6: Address 0 bit 3 squelches the receive output and bit 5 squelches the transmit output. A squelched output is all zeros whatever its invert bit says.
- R7: Both outputs are registered. A word present on an input before a clock edge appears on the output after that edge, and not before.
- R8: A write accepted at clock edge k does not affect the word registered at edge k. It takes effect on the word registered at edge k+1.
- R9: Writing address 1 with bit 0 set is a software reset. It clears all control bits and `cfgError`, and it does not persist: later control writes take effect normally.
- R10: Writes to addresses 2 and 3 change neither the routing, the polarity, the squelch nor `cfgError`.
- R11: While `rstN` is low, both outputs and `cfgError` are zero. After reset the block is in normal mode with no inversion and no squelch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (2) | Register write address |
| regWrData | input | 8 | Register write data |
| lineInWord | input | WORD_W (16) | Retimed line-side input word |
| hostInWord | input | WORD_W (16) | Retimed host-side input word |
| rxOutWord | output | WORD_W (16) | Receive-side (toward host) output word |
| txOutWord | output | WORD_W (16) | Transmit-side (toward line) output word |
| cfgError | output | 1 | Sticky flag for an illegal dual-loopback setting |

## Verification
The bench sweeps all 64 values of the control byte against several data patterns, using distinct line and host words. It checks both outputs and the error flag against a model computed from the bit meanings. A design that let the bypassed input leak onto the looped-back output, or that applied inversion after squelch, would show ones where zeros are expected. A design that chose line loopback when both bits are set would route the wrong source. Directed cases then probe the write-to-effect cycle, which a design without the one-cycle control delay would miss by one word. They also check that the error flag stays set after a legal write, that software reset clears itself, and that writes to unused addresses are ignored. A design that decoded too few address bits would change its routing on those writes.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  // Register addresses and bit positions of the control byte
  localparam int CTRL_ADDR   = 0;
  localparam int CMD_ADDR    = 1;
  localparam int BIT_SYSLOOP = 0;
  localparam int BIT_LNLOOP  = 1;
  localparam int BIT_RXINV   = 2;
  localparam int BIT_RXSQ    = 3;
  localparam int BIT_TXINV   = 4;
  localparam int BIT_TXSQ    = 5;
  localparam int BIT_SWRST   = 0;

  // Effective steering decisions sent from control to datapath
  typedef struct packed {
    logic rxFromHost;
    logic txFromLine;
    logic rxInvert;
    logic rxSquelch;
    logic txInvert;
    logic txSquelch;
  } steerCtrl_t;

endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output steerCtrl_t        steerStrobes,
  output logic              cfgError
);

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] CmdAddr  = ADDR_W'(CMD_ADDR);

  logic sysLoopQ, lineLoopQ, rxInvQ, rxSqQ, txInvQ, txSqQ, errQ;
  logic ctrlWrite, swReset, lineLoopEff;

  assign ctrlWrite = regWrEn && (regAddr == CtrlAddr);
  assign swReset   = regWrEn && (regAddr == CmdAddr) && regWrData[BIT_SWRST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysLoopQ  <= 1'b0;
      lineLoopQ <= 1'b0;
      rxInvQ    <= 1'b0;
      rxSqQ     <= 1'b0;
      txInvQ    <= 1'b0;
      txSqQ     <= 1'b0;
    end else if (swReset) begin
      sysLoopQ  <= 1'b0;
      lineLoopQ <= 1'b0;
      rxInvQ    <= 1'b0;
      rxSqQ     <= 1'b0;
      txInvQ    <= 1'b0;
      txSqQ     <= 1'b0;
    end else if (ctrlWrite) begin
      sysLoopQ  <= regWrData[BIT_SYSLOOP];
      lineLoopQ <= regWrData[BIT_LNLOOP];
      rxInvQ    <= regWrData[BIT_RXINV];
      rxSqQ     <= regWrData[BIT_RXSQ];
      txInvQ    <= regWrData[BIT_TXINV];
      txSqQ     <= regWrData[BIT_TXSQ];
    end
  end

  // Sticky flag: raised while both loopbacks are held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      errQ <= 1'b0;
    else if (swReset)               errQ <= 1'b0;
    else if (sysLoopQ && lineLoopQ) errQ <= 1'b1;
  end

  // System loopback has priority over line-side loopback
  assign lineLoopEff = lineLoopQ && !sysLoopQ;

  always_comb begin
    steerStrobes.rxFromHost = sysLoopQ;
    steerStrobes.txFromLine = lineLoopEff;
    steerStrobes.rxInvert   = rxInvQ;
    steerStrobes.rxSquelch  = rxSqQ || lineLoopEff;
    steerStrobes.txInvert   = txInvQ;
    steerStrobes.txSquelch  = txSqQ || sysLoopQ;
  end

  assign cfgError = errQ;

endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] primaryWord,
  input  logic [WORD_W-1:0] altWord,
  input  logic              useAlt,
  input  logic              invert,
  input  logic              squelch,
  output logic [WORD_W-1:0] outWord
);

  logic [WORD_W-1:0] srcWord, nextWord;

  always_comb begin
    srcWord = useAlt ? altWord : primaryWord;
    if (squelch)     nextWord = '0;
    else if (invert) nextWord = ~srcWord;
    else             nextWord = srcWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outWord <= '0;
    else       outWord <= nextWord;
  end

endmodule

// File: rtl/lane_steer_datapath.sv
module lane_steer_datapath
  import lane_steer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerCtrl_t        steerStrobes,
  input  logic [WORD_W-1:0] lineInWord,
  input  logic [WORD_W-1:0] hostInWord,
  output logic [WORD_W-1:0] rxOutWord,
  output logic [WORD_W-1:0] txOutWord
);

  localparam int NumLanes = 2;   // lane 0 = receive side, lane 1 = transmit side

  logic [WORD_W-1:0] primW [NumLanes];
  logic [WORD_W-1:0] altW  [NumLanes];
  logic [WORD_W-1:0] outW  [NumLanes];
  logic              selAlt[NumLanes];
  logic              invB  [NumLanes];
  logic              sqB   [NumLanes];

  always_comb begin
    primW[0]  = lineInWord;
    altW[0]   = hostInWord;
    selAlt[0] = steerStrobes.rxFromHost;
    invB[0]   = steerStrobes.rxInvert;
    sqB[0]    = steerStrobes.rxSquelch;
    primW[1]  = hostInWord;
    altW[1]   = lineInWord;
    selAlt[1] = steerStrobes.txFromLine;
    invB[1]   = steerStrobes.txInvert;
    sqB[1]    = steerStrobes.txSquelch;
  end

  for (genvar g = 0; g < NumLanes; g++) begin : gLane
    lane_out_stage #(.WORD_W(WORD_W)) u_stage (
      .clk        (clk),
      .rstN       (rstN),
      .primaryWord(primW[g]),
      .altWord    (altW[g]),
      .useAlt     (selAlt[g]),
      .invert     (invB[g]),
      .squelch    (sqB[g]),
      .outWord    (outW[g])
    );
  end

  assign rxOutWord = outW[0];
  assign txOutWord = outW[1];

endmodule

// File: rtl/lane_loop_steer.sv
module lane_loop_steer
  import lane_steer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [WORD_W-1:0] lineInWord,
  input  logic [WORD_W-1:0] hostInWord,
  output logic [WORD_W-1:0] rxOutWord,
  output logic [WORD_W-1:0] txOutWord,
  output logic              cfgError
);

  steerCtrl_t steerStrobes;

  lane_steer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .steerStrobes(steerStrobes),
    .cfgError    (cfgError)
  );

  lane_steer_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .steerStrobes(steerStrobes),
    .lineInWord  (lineInWord),
    .hostInWord  (hostInWord),
    .rxOutWord   (rxOutWord),
    .txOutWord   (txOutWord)
  );

endmodule

// File: rtl/lane_loop_steer_chk.sv
module lane_loop_steer_chk
  import lane_steer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input steerCtrl_t        strobes,
  input logic [WORD_W-1:0] lineInWord,
  input logic [WORD_W-1:0] hostInWord,
  input logic [WORD_W-1:0] rxOutWord,
  input logic [WORD_W-1:0] txOutWord,
  input logic              cfgError
);

  localparam logic [ADDR_W-1:0] CmdAddr = ADDR_W'(CMD_ADDR);

  a_r1_normal_rx: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!strobes.rxFromHost && !strobes.rxInvert && !strobes.rxSquelch))
      |-> rxOutWord == $past(lineInWord));

  a_r2_sysloop_rx: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.rxFromHost && !strobes.rxInvert && !strobes.rxSquelch))
      |-> rxOutWord == $past(hostInWord));

  a_r3_lineloop_tx: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.txFromLine && !strobes.txInvert && !strobes.txSquelch))
      |-> txOutWord == $past(lineInWord));

  a_r5_rx_invert: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!strobes.rxFromHost && strobes.rxInvert && !strobes.rxSquelch))
      |-> rxOutWord == ~$past(lineInWord));

  a_r6_rx_squelch: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.rxSquelch)) |-> rxOutWord == '0);

  a_r6_tx_squelch: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.txSquelch)) |-> txOutWord == '0);

  a_r4_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgError) && !$past(regWrEn && regAddr == CmdAddr && regWrData[BIT_SWRST]))
      |-> cfgError);

endmodule

bind lane_loop_steer lane_loop_steer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .strobes   (steerStrobes),
  .lineInWord(lineInWord),
  .hostInWord(hostInWord),
  .rxOutWord (rxOutWord),
  .txOutWord (txOutWord),
  .cfgError  (cfgError)
);

// File: tb/lane_loop_steer_bench.sv
`timescale 1ns/1ps
module lane_loop_steer_bench;

  localparam int W = 16;
  localparam int A = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [A-1:0] regAddr = '0;
  logic [7:0]   regWrData = '0;
  logic [W-1:0] lineInWord = '0;
  logic [W-1:0] hostInWord = '0;
  logic [W-1:0] rxOutWord, txOutWord;
  logic         cfgError;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_loop_steer #(.WORD_W(W), .ADDR_W(A)) u_lane_loop_steer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lineInWord(lineInWord), .hostInWord(hostInWord),
    .rxOutWord(rxOutWord), .txOutWord(txOutWord), .cfgError(cfgError)
  );

  // Model from the requirement bit meanings
  function automatic logic [W-1:0] expRx(logic [7:0] c, logic [W-1:0] ln, logic [W-1:0] hs);
    logic sys = c[0];
    logic lnl = c[1] & ~c[0];
    logic [W-1:0] src = sys ? hs : ln;
    if (c[3] | lnl) return '0;
    return c[2] ? ~src : src;
  endfunction

  function automatic logic [W-1:0] expTx(logic [7:0] c, logic [W-1:0] ln, logic [W-1:0] hs);
    logic sys = c[0];
    logic lnl = c[1] & ~c[0];
    logic [W-1:0] src = lnl ? ln : hs;
    if (c[5] | sys) return '0;
    return c[4] ? ~src : src;
  endfunction

  function automatic logic [W-1:0] pat(int p);
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h1234;
      default: return 16'hC3A5;
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write lasts one edge; returns at the following negedge
  task automatic writeReg(logic [A-1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic driveAndCheck(string tag, logic [7:0] c, logic [W-1:0] ln, logic [W-1:0] hs, logic expErr);
    lineInWord = ln; hostInWord = hs;
    @(negedge clk);
    chk({tag, " rx"}, rxOutWord, expRx(c, ln, hs));
    chk({tag, " tx"}, txOutWord, expTx(c, ln, hs));
    chk({tag, " err"}, W'(cfgError), W'(expErr));
  endtask

  initial begin
    // R11: reset state
    lineInWord = 16'hBEEF; hostInWord = 16'h7777;
    repeat (3) @(negedge clk);
    chk("R11 reset rx", rxOutWord, '0);
    chk("R11 reset tx", txOutWord, '0);
    chk("R11 reset err", W'(cfgError), '0);
    rstN = 1'b1;
    @(negedge clk);
    driveAndCheck("R11 post-reset normal", 8'h00, 16'h1357, 16'h2468, 1'b0);

    // R7: output holds until the clock edge
    lineInWord = 16'hAAAA; hostInWord = 16'h5555;
    #1;
    chk("R7 no early rx", rxOutWord, 16'h1357);
    @(negedge clk);
    chk("R7 one-cycle rx", rxOutWord, 16'hAAAA);
    chk("R7 one-cycle tx", txOutWord, 16'h5555);

    // Sweep all control bytes: R1 R2 R3 R4 R5 R6
    for (int c = 0; c < 64; c++) begin
      writeReg(2'd1, 8'h01);
      writeReg(2'd0, 8'(c));
      for (int p = 0; p < 4; p++) begin
        logic [W-1:0] ln = pat(p);
        logic [W-1:0] hs = pat(p) ^ 16'h5A0F;
        driveAndCheck("R1/R2/R3/R4/R5/R6 sweep", 8'(c), ln, hs, (c & 3) == 3);
      end
    end

    // R8: write at edge k affects word at k+1 only
    writeReg(2'd1, 8'h01);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h04;
    lineInWord = 16'h0F0F; hostInWord = 16'h1111;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R8 old config at write edge", rxOutWord, 16'h0F0F);
    lineInWord = 16'h3C3C;
    @(negedge clk);
    chk("R8 new config next edge", rxOutWord, ~16'h3C3C);

    // R4: error sticks after a legal write
    writeReg(2'd0, 8'h03);
    writeReg(2'd0, 8'h00);
    driveAndCheck("R4 sticky after legal write", 8'h00, 16'h4321, 16'h8765, 1'b1);

    // R9: software reset clears control and error, then does not persist
    writeReg(2'd0, 8'h3E);
    writeReg(2'd1, 8'h01);
    driveAndCheck("R9 after soft reset", 8'h00, 16'h9999, 16'h6666, 1'b0);
    writeReg(2'd0, 8'h10);
    driveAndCheck("R9 writes work after soft reset", 8'h10, 16'h9999, 16'h6666, 1'b0);

    // R10: unused addresses have no effect
    writeReg(2'd0, 8'h00);
    writeReg(2'd2, 8'h3F);
    writeReg(2'd3, 8'h3F);
    driveAndCheck("R10 ignored address writes", 8'h00, 16'hABCD, 16'h0123, 1'b0);
    writeReg(2'd1, 8'h00);
    driveAndCheck("R10 cmd without reset bit", 8'h00, 16'hABCD, 16'h0123, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule